// File: doc/BRIEF.md
# Bit-Serial Register Slave with Write Key and Shadow Verification

The block is the peripheral side of a small converter's control port. A host talks to it over a four-wire serial link (SPI mode 0) using 16-bit frames, and every frame travels least-significant bit first on both data lines. Each frame has three fields. Bits 15:11 are a 5-bit register address, bit 10 is the direction flag (1 = write), and bits 9:0 are a 10-bit data field. A read takes two frames. The first is a command frame with the direction flag clear. After chip select is released and asserted again, the second frame shifts out the addressed register in bits 9:0, with bits 15:10 zero.

Writes are normally refused. They are accepted only while the write-enable register at address 0x0C holds the key 0x294. The key register can itself be written at any time, and writing any other value locks the block again. The eight configuration registers at 0x03..0x0A each have a verification copy at address + 0x10 (0x13..0x1A). A memory-validation fault output stays high while any primary register differs from its copy. The same fault can be read as bit 0 of the flags register at 0x02. Bit 5 of the configuration register at 0x09 drives the external-reference select output. Registers 0x00 and 0x01 return the converter result and the filtered result, which are captured every clock from two parallel input buses.

The serial pins are brought into the system clock domain through synchronisers. The serial clock must therefore run well below the system clock, with each serial half-period lasting at least six system clocks.

Top module: `lsbspi_regslave`

## Requirements
- R1: Frames are 16 bits and are shifted least-significant bit first on both data lines. Bits 15:11 carry the address, bit 10 the write flag (1 = write), and bits 9:0 the data. Input is sampled on the rising serial-clock edge, and output changes after the falling edge.
- R2: After a read command frame, the next frame returns the addressed register in bits 9:0 with bits 15:10 zero.
- R3: Address 0x0C is writable in every state and reads back the value last written. Writes to other addresses are enabled only while it holds 0x294. Writing 0 or any other value disables them again.
- R4: While writes are disabled, a write frame to any address other than 0x0C changes no register and no output.
- R5: Verification registers 0x13..0x1A can be written while writes are enabled and read back independently of their primaries at 0x03..0x0A.
- R6: `mv_fault` is high exactly while some register at 0x03..0x0A differs from its copy at address + 0x10. Flags register 0x02 returns that fault in bit 0, and its other bits read zero.
- R7: Reads of 0x0B, 0x0D..0x12, 0x1B..0x1F return zero. Writes to 0x00..0x02 and to unmapped addresses have no effect.
- R8: `ext_ref` equals bit 5 of the configuration register at 0x09.
- R9: Reads of 0x00 and 0x01 return the current values of `adc_in` and `fadc_in`.
- R10: A frame cut short by chip select rising before its 16th bit has no effect.
- R11: After reset, every register is zero, so `mv_fault`, `ext_ref` and `spi_miso` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host, LSB first |
| spi_miso | output | 1 | Serial data to host, LSB first, low while deselected |
| adc_in | input | 10 | Converter result, returned at address 0x00 |
| fadc_in | input | 10 | Filtered converter result, returned at address 0x01 |
| ext_ref | output | 1 | External reference select (configuration bit 5) |
| mv_fault | output | 1 | Memory-validation fault |

## Verification
The hardest states to reach from the pins are those where a write is refused or lost. Examples are a locked write, a wrong key, or a frame cut short after ten bits. In each of these the correct result is that nothing changes, so the only way to see it is to observe state. The stimulus first builds visible state by unlocking and setting configuration bit 5, which raises `ext_ref` and, with its copy left unwritten, also raises `mv_fault`. It then applies the refused or truncated frame and reads both the pins and the register back over the serial link. The fault is driven from both sides: first a primary is written alone and then its copy, and later a copy is written alone and then its primary.

// File: rtl/lsbspi_pkg.sv
// Package: shared constants for the bit-serial register slave.
// Assumes a 5-bit address, a 1-bit direction flag and a 10-bit data field.
package lsbspi_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 10;
    localparam int FRAME_W   = ADDR_W + 1 + DATA_W;
    localparam int CFG_LO    = 3;      // first shadowed register
    localparam int N_CFG     = 8;      // 0x03..0x0A
    localparam int VER_OFS   = 16;     // copy sits at address + 0x10
    localparam int WEN_ADDR  = 12;     // key register
    localparam int KEY_VAL   = 'h294;
    localparam int CFG_ADDR  = 9;      // configuration register
    localparam int EXT_BIT   = 5;      // external reference select bit
    localparam int ADC_ADDR  = 0;
    localparam int FADC_ADDR = 1;
    localparam int FLAG_ADDR = 2;
endpackage

// File: rtl/lsbspi_frame.sv
// Module: serial frame engine. Synchronises the serial pins into clk,
// assembles LSB-first frames on rising serial-clock edges and shifts the
// response word out LSB first after each falling edge. A frame shorter than
// FRAME_W bits is discarded when chip select rises.
// Assumes each serial half-period spans several system clocks.
module lsbspi_frame #(
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [FRAME_W-1:0] rsp_word,
    output logic               miso,
    output logic               frm_vld,
    output logic [FRAME_W-1:0] frm_word,
    output logic               tx_evt
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [2:0] PIN_IDLE = 3'b010;   // {sclk, cs_n, mosi}

    logic [2:0]         stg [SYNC_STAGES];
    logic               sclk_s, cs_s, mosi_s, sclk_d, cs_d;
    logic               rise, fall, cs_fall, cs_rise;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sh_q, tx_q;

    // Synchronise the three serial pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= PIN_IDLE;
        end else begin
            stg[0] <= {sclk, cs_n, mosi};
            for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign {sclk_s, cs_s, mosi_s} = stg[SYNC_STAGES-1];

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign rise    = sclk_s & ~sclk_d & ~cs_s;
    assign fall    = ~sclk_s & sclk_d & ~cs_s;
    assign cs_fall = ~cs_s & cs_d;
    assign cs_rise = cs_s & ~cs_d;
    assign tx_evt  = fall | cs_fall | cs_rise;

    // Shift incoming bits in from the top so the first bit lands in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            frm_vld  <= 1'b0;
            frm_word <= '0;
        end else begin
            frm_vld <= 1'b0;
            if (cs_s) begin
                cnt_q <= '0;
            end else if (rise) begin
                sh_q  <= {mosi_s, sh_q[FRAME_W-1:1]};
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    frm_vld  <= 1'b1;
                    frm_word <= {mosi_s, sh_q[FRAME_W-1:1]};
                end
            end
        end
    end

    // Load the response at frame start and step it right after each fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_q <= '0;
        else if (cs_fall) tx_q <= rsp_word;
        else if (fall)    tx_q <= tx_q >> 1;
    end

    assign miso = ~cs_s & tx_q[0];
endmodule

// File: rtl/lsbspi_regs.sv
// Module: register bank. Holds the key register, the configuration
// registers with their verification copies, and the captured converter
// results. Produces the read mux, the fault and the reference select.
// Assumes at most one write strobe per cycle, all widths from the package.
module lsbspi_regs
    import lsbspi_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NC = N_CFG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] adc_in,
    input  logic [DW-1:0] fadc_in,
    output logic [DW-1:0] rd_data,
    output logic          key_ok,
    output logic          mv_fault,
    output logic          ext_ref
);
    localparam int CFG_IDX = CFG_ADDR - CFG_LO;

    logic [DW-1:0] prim_q [NC];
    logic [DW-1:0] ver_q  [NC];
    logic [DW-1:0] wen_q, adc_q, fadc_q;
    logic [NC-1:0] diff;

    assign key_ok = (wen_q == DW'(KEY_VAL));

    // Key register: writable regardless of lock state.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   wen_q <= '0;
        else if (wr_stb && wr_addr == AW'(WEN_ADDR))  wen_q <= wr_data;
    end

    // Primary and verification registers, written only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) begin
                prim_q[i] <= '0;
                ver_q[i]  <= '0;
            end
        end else if (wr_stb && key_ok) begin
            for (int i = 0; i < NC; i++) begin
                if (wr_addr == AW'(CFG_LO + i))           prim_q[i] <= wr_data;
                if (wr_addr == AW'(CFG_LO + i + VER_OFS)) ver_q[i]  <= wr_data;
            end
        end
    end

    // Capture the parallel converter results every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_q  <= '0;
            fadc_q <= '0;
        end else begin
            adc_q  <= adc_in;
            fadc_q <= fadc_in;
        end
    end

    // One comparator per primary/copy pair.
    for (genvar g = 0; g < NC; g++) begin : g_cmp
        assign diff[g] = (prim_q[g] != ver_q[g]);
    end

    assign mv_fault = |diff;
    assign ext_ref  = prim_q[CFG_IDX][EXT_BIT];

    // Read mux: mapped addresses return their value, all others zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADC_ADDR))  rd_data = adc_q;
        if (rd_addr == AW'(FADC_ADDR)) rd_data = fadc_q;
        if (rd_addr == AW'(FLAG_ADDR)) rd_data = DW'(mv_fault);
        if (rd_addr == AW'(WEN_ADDR))  rd_data = wen_q;
        for (int i = 0; i < NC; i++) begin
            if (rd_addr == AW'(CFG_LO + i))           rd_data = prim_q[i];
            if (rd_addr == AW'(CFG_LO + i + VER_OFS)) rd_data = ver_q[i];
        end
    end
endmodule

// File: rtl/lsbspi_regslave.sv
// Module: top of the bit-serial register slave. Splits each received frame
// into address, direction and data, forwards writes to the register bank and
// latches the read result as the response for the next frame.
// Assumes SPI mode 0 and a serial clock well below clk.
module lsbspi_regslave
    import lsbspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [DATA_W-1:0] adc_in,
    input  logic [DATA_W-1:0] fadc_in,
    output logic              ext_ref,
    output logic              mv_fault
);
    logic               frm_vld, tx_evt, key_ok, frm_wr;
    logic [FRAME_W-1:0] frm_word, rsp_q;
    logic [ADDR_W-1:0]  frm_addr;
    logic [DATA_W-1:0]  frm_data, rd_data;

    assign frm_addr = frm_word[FRAME_W-1 -: ADDR_W];
    assign frm_wr   = frm_word[DATA_W];
    assign frm_data = frm_word[DATA_W-1:0];

    lsbspi_frame #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .rsp_word(rsp_q), .miso(spi_miso),
        .frm_vld(frm_vld), .frm_word(frm_word), .tx_evt(tx_evt)
    );

    lsbspi_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(frm_vld & frm_wr), .wr_addr(frm_addr), .wr_data(frm_data),
        .rd_addr(frm_addr), .adc_in(adc_in), .fadc_in(fadc_in),
        .rd_data(rd_data), .key_ok(key_ok),
        .mv_fault(mv_fault), .ext_ref(ext_ref)
    );

    // Latch the addressed value when a read command frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rsp_q <= '0;
        else if (frm_vld & ~frm_wr) rsp_q <= FRAME_W'(rd_data);
    end
endmodule

// File: rtl/lsbspi_checker.sv
// Module: protocol checker bound to the top. Relates frame completion to
// visible state changes and the serial output to its shift events.
module lsbspi_checker #(
    parameter int AW      = 5,
    parameter int WEN_A   = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frm_vld,
    input logic          frm_wr,
    input logic [AW-1:0] frm_addr,
    input logic          key_ok,
    input logic          tx_evt,
    input logic          spi_miso,
    input logic          ext_ref,
    input logic          mv_fault
);
    // R1: a completed frame is a single-cycle event.
    a_r1_single_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |=> !frm_vld);

    // R1: serial output moves only on a falling edge or a chip-select edge.
    a_r1_miso_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_evt |=> $stable(spi_miso));

    // R8: reference select changes only right after a frame.
    a_r8_extref_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> $stable(ext_ref));

    // R6: fault changes only right after a frame.
    a_r6_fault_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_vld |=> $stable(mv_fault));

    // R4: a locked write outside the key register changes nothing visible.
    a_r4_locked_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_wr && !key_ok && frm_addr != AW'(WEN_A))
        |=> ($stable(ext_ref) && $stable(mv_fault)));
endmodule

bind lsbspi_regslave lsbspi_checker #(.AW(lsbspi_pkg::ADDR_W), .WEN_A(lsbspi_pkg::WEN_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_wr(frm_wr),
    .frm_addr(frm_addr), .key_ok(key_ok), .tx_evt(tx_evt),
    .spi_miso(spi_miso), .ext_ref(ext_ref), .mv_fault(mv_fault)
);

// File: tb/test_lsbspi_regslave.sv
`timescale 1ns/1ps
module test_lsbspi_regslave;
    localparam int H = 8;   // system clocks per serial half-period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, ext_ref, mv_fault;
    logic [9:0] adc_in = '0, fadc_in = '0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lsbspi_regslave i_lsbspi_regslave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .adc_in(adc_in), .fadc_in(fadc_in),
        .ext_ref(ext_ref), .mv_fault(mv_fault)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One chip-select window of nbits bits, LSB first both ways.
    task automatic xfer(input logic [15:0] tx, output logic [15:0] rx, input int nbits);
        rx = '0;
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[i];
            wait_clk(H);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(H);
            sclk = 1'b0;
        end
        wait_clk(H);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(H);
    endtask

    task automatic wr(input logic [4:0] a, input logic [9:0] d);
        logic [15:0] rx;
        xfer({a, 1'b1, d}, rx, 16);
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        logic [15:0] rx;
        xfer({a, 1'b0, 10'h000}, rx, 16);
        xfer(16'h0000, d, 16);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R11 mv_fault", {15'b0, mv_fault}, 16'h0);
        check("R11 ext_ref", {15'b0, ext_ref}, 16'h0);
        check("R11 miso idle", {15'b0, miso}, 16'h0);
        rd(5'h09, d); check("R11 cfg reset", d, 16'h0000);
        rd(5'h0C, d); check("R11 key reset", d, 16'h0000);
    endtask

    task automatic t_adc;
        logic [15:0] d;
        adc_in = 10'h2A5; fadc_in = 10'h15A;
        rd(5'h00, d); check("R9 R1 R2 adc", d, 16'h02A5);
        rd(5'h01, d); check("R9 R2 fadc", d, 16'h015A);
        adc_in = 10'h3FF;
        rd(5'h00, d); check("R9 R2 adc full", d, 16'h03FF);
    endtask

    task automatic t_locked;
        logic [15:0] d;
        wr(5'h09, 10'h020);
        check("R4 ext_ref locked", {15'b0, ext_ref}, 16'h0);
        check("R4 fault locked", {15'b0, mv_fault}, 16'h0);
        rd(5'h09, d); check("R4 cfg locked", d, 16'h0000);
    endtask

    task automatic t_unlock;
        logic [15:0] d;
        wr(5'h0C, 10'h294);
        rd(5'h0C, d); check("R3 key readback", d, 16'h0294);
        wr(5'h09, 10'h020);
        check("R8 ext_ref set", {15'b0, ext_ref}, 16'h1);
        check("R6 fault primary only", {15'b0, mv_fault}, 16'h1);
        rd(5'h02, d); check("R6 flags bit0", d, 16'h0001);
    endtask

    task automatic t_verify;
        logic [15:0] d;
        wr(5'h19, 10'h020);
        check("R6 fault cleared", {15'b0, mv_fault}, 16'h0);
        rd(5'h19, d); check("R5 copy readback", d, 16'h0020);
        rd(5'h02, d); check("R6 flags clear", d, 16'h0000);
        wr(5'h03, 10'h155);
        check("R6 fault low pair", {15'b0, mv_fault}, 16'h1);
        rd(5'h13, d); check("R5 copy independent", d, 16'h0000);
        wr(5'h13, 10'h155);
        check("R6 fault low pair fixed", {15'b0, mv_fault}, 16'h0);
        wr(5'h1A, 10'h3FF);
        check("R6 fault copy side", {15'b0, mv_fault}, 16'h1);
        wr(5'h0A, 10'h3FF);
        check("R6 fault high pair fixed", {15'b0, mv_fault}, 16'h0);
        rd(5'h0A, d); check("R5 primary readback", d, 16'h03FF);
    endtask

    task automatic t_unmapped;
        logic [15:0] d;
        wr(5'h0B, 10'h123);
        rd(5'h0B, d); check("R7 write-only reads 0", d, 16'h0000);
        rd(5'h0D, d); check("R7 gap reads 0", d, 16'h0000);
        rd(5'h1F, d); check("R7 top reads 0", d, 16'h0000);
        wr(5'h10, 10'h0AA);
        rd(5'h10, d); check("R7 0x10 ignored", d, 16'h0000);
        wr(5'h00, 10'h111);
        rd(5'h00, d); check("R7 adc not writable", d, 16'h03FF);
        wr(5'h02, 10'h3FF);
        rd(5'h02, d); check("R7 flags not writable", d, 16'h0000);
        check("R7 fault unaffected", {15'b0, mv_fault}, 16'h0);
    endtask

    task automatic t_abort;
        logic [15:0] rx, d;
        xfer({5'h09, 1'b1, 10'h000}, rx, 10);
        check("R10 ext_ref kept", {15'b0, ext_ref}, 16'h1);
        rd(5'h09, d); check("R10 cfg kept", d, 16'h0020);
    endtask

    task automatic t_relock;
        logic [15:0] d;
        wr(5'h0C, 10'h000);
        wr(5'h09, 10'h000);
        check("R3 R4 relocked", {15'b0, ext_ref}, 16'h1);
        wr(5'h0C, 10'h295);
        rd(5'h0C, d); check("R3 wrong key readback", d, 16'h0295);
        wr(5'h19, 10'h000);
        check("R3 R4 wrong key locked", {15'b0, mv_fault}, 16'h0);
        rd(5'h19, d); check("R4 copy kept", d, 16'h0020);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_adc();
        t_locked();
        t_unlock();
        t_verify();
        t_unmapped();
        t_abort();
        t_relock();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule